// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the interrupt, status and configuration registers of a flash memory controller's host interface. A 16-bit host bus reads and writes five registers: an interrupt status word, a controller status word, two system configuration words and a write-protect status word. A command engine, which is outside this block, reports each finished operation with a one-cycle done pulse and each failure with a one-cycle error pulse. Each pulse carries a 2-bit operation kind.

The block drives an interrupt line whose polarity is chosen by a configuration bit. It also drives a ready line taken from another configuration bit. The host acknowledges work by writing an AND mask to the interrupt status word. Once the master completion flag drops, the accumulated error flags in the controller status word are wiped in the same cycle. A cold reset and a warm reset load different interrupt status values, so software can tell which of the two occurred.

Register addresses on `bus_addr`: 0 interrupt status, 1 controller status, 2 configuration word 0, 3 configuration word 1, 4 write-protect status. Addresses 5 to 7 are unmapped. Operation kinds on `evt_op`: 0 reset, 1 erase, 2 program, 3 load.

Top module: `flash_irq_ctrl`

## Requirements
- R1: While `rst_cold` is high, the interrupt status is loaded with 0x8080, the controller status with 0x0000, configuration word 0 with 0x40C0, configuration word 1 with 0x0000 and the write-protect status with 0x0002; `irq` and `ready` are 1. `rst_cold` takes priority over `rst_warm`.
- R2: While only `rst_warm` is high, the values are the same as in R1 except that the interrupt status is loaded with 0x8010.
- R3: A host write to address 0 replaces the interrupt status with (old value AND written value).
- R4: When a host write to address 0 leaves interrupt status bit 15 at 0, controller status bits 13:10 are cleared in the same cycle. When bit 15 stays at 1, those bits are kept.
- R5: A done pulse sets interrupt status bit 15 and bit 4+`evt_op`, so bit 4 for reset, 5 for erase, 6 for program and 7 for load.
- R6: An error pulse sets controller status bit 10 (command error) and bit 10+`evt_op`, so bit 11 for erase, 12 for program and 13 for load. A reset-kind error sets only bit 10.
- R7: `irq` equals interrupt status bit 15 XOR NOT configuration word 0 bit 6. It is registered and follows a change of either register one clock later.
- R8: A host write to address 2 drives `ready` to bit 7 of the written value on the same clock edge that stores the word.
- R9: A read of address 2 returns configuration word 0 with bits 4:0 forced to 0. Address 3 reads back all 16 bits as written.
- R10: Host writes to addresses 1, 4 and 5 to 7 have no effect on any register.
- R11: When a host write to address 0 and a done or error pulse fall in the same cycle, the event bits are ORed in after the mask is applied. A done pulse that sets bit 15 in that cycle keeps the error flags from being wiped.
- R12: `bus_rdata` is registered: it shows the addressed register one clock after `bus_rd` is sampled high, and holds its value otherwise. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous cold reset, active high |
| rst_warm | input | 1 | Synchronous warm reset, active high |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered host read data |
| evt_done | input | 1 | Operation completed pulse |
| evt_err | input | 1 | Operation failed pulse |
| evt_op | input | 2 | Operation kind of the pulse |
| irq | output | 1 | Interrupt line, polarity set by configuration |
| ready | output | 1 | Ready line from configuration word 0 bit 7 |

## Verification
The bench goes after the reset value that tells cold and warm reset apart. A design that ignored the reset kind would show 0x8080 after a warm reset. It checks that the interrupt write is an AND and not a plain store or a write-one-to-clear; either of those would leave the wrong bits set. It checks that error flags survive a mask that keeps bit 15 but vanish with one that clears it; a design that wiped them on every write, or never wiped them, would be caught there. The bench also checks a mask write that collides with a done pulse: a design that let the mask win would lose the new completion and wrongly wipe the errors. Finally it checks the polarity inversion and the masked low bits of configuration word 0, where an inverted XOR or an unmasked read would give the wrong level or value.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  localparam int DW       = 16;
  localparam int AW       = 3;
  localparam int OPS      = 4;
  localparam int OP_W     = $clog2(OPS);

  // interrupt status bit layout
  localparam int INT_MASTER = 15;
  localparam int DONE_BASE  = 4;
  // controller status bit layout
  localparam int ERR_BASE   = 10;
  localparam logic [DW-1:0] ERR_MASK = 16'h3C00;

  // configuration word 0 fields
  localparam int CFG_POL_BIT = 6;
  localparam int CFG_RDY_BIT = 7;
  localparam logic [DW-1:0] CFG0_RD_MASK = 16'hFFE0;

  // reset images
  localparam logic [DW-1:0] INT_RST_COLD = 16'h8080;
  localparam logic [DW-1:0] INT_RST_WARM = 16'h8010;
  localparam logic [DW-1:0] CFG0_RST     = 16'h40C0;
  localparam logic [DW-1:0] CFG1_RST     = 16'h0000;
  localparam logic [DW-1:0] WP_RST       = 16'h0002;

  typedef enum logic [AW-1:0] {
    REG_INT  = 3'd0,
    REG_CTRL = 3'd1,
    REG_CFG0 = 3'd2,
    REG_CFG1 = 3'd3,
    REG_WP   = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/fis_event_dec.sv
module fis_event_dec
  import flash_irq_pkg::*;
(
  input  logic            evt_done,
  input  logic            evt_err,
  input  logic [OP_W-1:0] evt_op,
  output logic [DW-1:0]   int_set,
  output logic [DW-1:0]   ctrl_set
);

  logic [OPS-1:0] op_hot;

  for (genvar g = 0; g < OPS; g++) begin : g_op
    assign op_hot[g] = (evt_op == OP_W'(g));
  end

  always_comb begin
    int_set  = '0;
    ctrl_set = '0;
    if (evt_done) begin
      int_set[INT_MASTER] = 1'b1;
      for (int i = 0; i < OPS; i++)
        if (op_hot[i]) int_set[DONE_BASE + i] = 1'b1;
    end
    if (evt_err) begin
      ctrl_set[ERR_BASE] = 1'b1;
      for (int i = 0; i < OPS; i++)
        if (op_hot[i]) ctrl_set[ERR_BASE + i] = 1'b1;
    end
  end

endmodule

// File: rtl/fis_status_regs.sv
module fis_status_regs
  import flash_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_cold,
  input  logic          rst_warm,
  input  logic          int_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] int_set,
  input  logic [DW-1:0] ctrl_set,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] ctrl_q
);

  logic [DW-1:0] int_n;
  logic [DW-1:0] ctrl_n;
  logic          wipe_err;

  always_comb begin
    int_n    = (int_wr ? (int_q & wdata) : int_q) | int_set;
    wipe_err = int_wr && !int_n[INT_MASTER];
    ctrl_n   = (wipe_err ? (ctrl_q & ~ERR_MASK) : ctrl_q) | ctrl_set;
  end

  always_ff @(posedge clk) begin
    if (rst_cold) begin
      int_q  <= INT_RST_COLD;
      ctrl_q <= '0;
    end else if (rst_warm) begin
      int_q  <= INT_RST_WARM;
      ctrl_q <= '0;
    end else begin
      int_q  <= int_n;
      ctrl_q <= ctrl_n;
    end
  end

endmodule

// File: rtl/fis_cfg_regs.sv
module fis_cfg_regs
  import flash_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg0_wr,
  input  logic          cfg1_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg0_q,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] wp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= CFG1_RST;
      wp_q   <= WP_RST;
    end else begin
      if (cfg0_wr) cfg0_q <= wdata;
      if (cfg1_wr) cfg1_q <= wdata;
    end
  end

endmodule

// File: rtl/fis_pin_drv.sv
module fis_pin_drv
  import flash_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master_flag,
  input  logic pol_bit,
  input  logic rdy_wr,
  input  logic rdy_val,
  output logic irq,
  output logic ready
);

  localparam logic IRQ_RST = INT_RST_COLD[INT_MASTER] ^ ~CFG0_RST[CFG_POL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= IRQ_RST;
      ready <= CFG0_RST[CFG_RDY_BIT];
    end else begin
      irq <= master_flag ^ ~pol_bit;
      if (rdy_wr) ready <= rdy_val;
    end
  end

endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_cold,
  input  logic            rst_warm,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            evt_done,
  input  logic            evt_err,
  input  logic [OP_W-1:0] evt_op,
  output logic            irq,
  output logic            ready
);

  logic          rst_any;
  logic          wr_int, wr_cfg0, wr_cfg1;
  logic [DW-1:0] int_set, ctrl_set;
  logic [DW-1:0] int_q, ctrl_q, cfg0_q, cfg1_q, wp_q;
  logic [DW-1:0] rd_mux;

  assign rst_any = rst_cold | rst_warm;
  assign wr_int  = bus_wr && (bus_addr == REG_INT);
  assign wr_cfg0 = bus_wr && (bus_addr == REG_CFG0);
  assign wr_cfg1 = bus_wr && (bus_addr == REG_CFG1);

  fis_event_dec u_dec (
    .evt_done (evt_done),
    .evt_err  (evt_err),
    .evt_op   (evt_op),
    .int_set  (int_set),
    .ctrl_set (ctrl_set)
  );

  fis_status_regs u_stat (
    .clk      (clk),
    .rst_cold (rst_cold),
    .rst_warm (rst_warm),
    .int_wr   (wr_int),
    .wdata    (bus_wdata),
    .int_set  (int_set),
    .ctrl_set (ctrl_set),
    .int_q    (int_q),
    .ctrl_q   (ctrl_q)
  );

  fis_cfg_regs u_cfg (
    .clk     (clk),
    .rst     (rst_any),
    .cfg0_wr (wr_cfg0),
    .cfg1_wr (wr_cfg1),
    .wdata   (bus_wdata),
    .cfg0_q  (cfg0_q),
    .cfg1_q  (cfg1_q),
    .wp_q    (wp_q)
  );

  fis_pin_drv u_pin (
    .clk         (clk),
    .rst         (rst_any),
    .master_flag (int_q[INT_MASTER]),
    .pol_bit     (cfg0_q[CFG_POL_BIT]),
    .rdy_wr      (wr_cfg0),
    .rdy_val     (bus_wdata[CFG_RDY_BIT]),
    .irq         (irq),
    .ready       (ready)
  );

  always_comb begin
    case (bus_addr)
      REG_INT:  rd_mux = int_q;
      REG_CTRL: rd_mux = ctrl_q;
      REG_CFG0: rd_mux = cfg0_q & CFG0_RD_MASK;
      REG_CFG1: rd_mux = cfg1_q;
      REG_WP:   rd_mux = wp_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
  import flash_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_cold,
  input logic            rst_warm,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            evt_done,
  input logic            evt_err,
  input logic [OP_W-1:0] evt_op,
  input logic [DW-1:0]   int_q,
  input logic [DW-1:0]   ctrl_q,
  input logic [DW-1:0]   cfg0_q,
  input logic            irq,
  input logic            ready
);

  logic rst;
  logic armed;
  assign rst = rst_cold | rst_warm;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    else if (armed === 1'bx) armed <= 1'b0;
  end

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (armed === 1'b1) |=> irq == $past(int_q[INT_MASTER] ^ ~cfg0_q[CFG_POL_BIT]));

  assert_and_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_INT && !evt_done) |=> int_q == ($past(int_q) & $past(bus_wdata)));

  assert_err_wipe_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_INT && !evt_done && !evt_err &&
     !(int_q[INT_MASTER] & bus_wdata[INT_MASTER])) |=> (ctrl_q & ERR_MASK) == '0);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> int_q[INT_MASTER] && int_q[DONE_BASE + int'($past(evt_op))]);

  assert_err_sets_R6: assert property (@(posedge clk) disable iff (rst)
    evt_err |=> ctrl_q[ERR_BASE] && ctrl_q[ERR_BASE + int'($past(evt_op))]);

  assert_ready_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_CFG0) |=> ready == $past(bus_wdata[CFG_RDY_BIT]));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == REG_CFG0) |=> $stable(cfg0_q));

endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_cold  (rst_cold),
  .rst_warm  (rst_warm),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_done  (evt_done),
  .evt_err   (evt_err),
  .evt_op    (evt_op),
  .int_q     (int_q),
  .ctrl_q    (ctrl_q),
  .cfg0_q    (cfg0_q),
  .irq       (irq),
  .ready     (ready)
);

// File: tb/flash_irq_ctrl_tb.sv
module flash_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_cold, rst_warm;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        evt_done, evt_err;
  logic [1:0]  evt_op;
  logic        irq, ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_irq_ctrl u_dut (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(evt_done), .evt_err(evt_err), .evt_op(evt_op),
    .irq(irq), .ready(ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cold);
    @(negedge clk);
    rst_cold = cold; rst_warm = ~cold;
    @(negedge clk); @(negedge clk);
    rst_cold = 1'b0; rst_warm = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic done, input logic err, input logic [1:0] op);
    @(negedge clk);
    evt_done = done; evt_err = err; evt_op = op;
    @(negedge clk);
    evt_done = 1'b0; evt_err = 1'b0;
  endtask

  task automatic t_cold_reset;
    logic [15:0] v;
    do_reset(1'b1);
    chk("R1 irq", {15'd0, irq}, 16'd1);
    chk("R1 ready", {15'd0, ready}, 16'd1);
    rd(3'd0, v); chk("R1 int", v, 16'h8080);
    rd(3'd1, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd2, v); chk("R1 cfg0", v, 16'h40C0);
    rd(3'd3, v); chk("R1 cfg1", v, 16'h0000);
    rd(3'd4, v); chk("R1 wp", v, 16'h0002);
  endtask

  task automatic t_warm_reset;
    logic [15:0] v;
    wr(3'd3, 16'h1234);
    pulse(1'b0, 1'b1, 2'd2);
    do_reset(1'b0);
    rd(3'd0, v); chk("R2 int", v, 16'h8010);
    rd(3'd1, v); chk("R2 ctrl", v, 16'h0000);
    rd(3'd3, v); chk("R2 cfg1", v, 16'h0000);
    chk("R2 irq", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_and_mask;
    logic [15:0] v;
    do_reset(1'b1);
    wr(3'd0, 16'hFF7F);
    rd(3'd0, v); chk("R3 and keep", v, 16'h8000);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R3 and clear", v, 16'h0000);
  endtask

  task automatic t_done_events;
    logic [15:0] v;
    for (int op = 0; op < 4; op++) begin
      wr(3'd0, 16'h0000);
      pulse(1'b1, 1'b0, 2'(op));
      rd(3'd0, v);
      chk("R5 done bit", v, 16'h8000 | (16'h0010 << op));
    end
  endtask

  task automatic t_err_events;
    logic [15:0] v;
    do_reset(1'b1);
    pulse(1'b0, 1'b1, 2'd0);
    rd(3'd1, v); chk("R6 reset-kind err", v, 16'h0400);
    pulse(1'b0, 1'b1, 2'd1);
    pulse(1'b0, 1'b1, 2'd3);
    rd(3'd1, v); chk("R6 erase+load err", v, 16'h2C00);
    pulse(1'b0, 1'b1, 2'd2);
    wr(3'd0, 16'h8000);
    rd(3'd1, v); chk("R4 keep errs while master set", v, 16'h3C00);
    wr(3'd0, 16'h7FFF);
    rd(3'd1, v); chk("R4 wipe errs", v, 16'h0000);
  endtask

  task automatic t_polarity;
    do_reset(1'b1);
    wr(3'd2, 16'h0080);
    @(negedge clk);
    chk("R7 low-active asserted", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0000);
    @(negedge clk);
    chk("R7 low-active idle", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h0040);
    chk("R8 ready low", {15'd0, ready}, 16'd0);
    @(negedge clk);
    chk("R7 high-active idle", {15'd0, irq}, 16'd0);
    pulse(1'b1, 1'b0, 2'd1);
    chk("R7 not yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R7 high-active asserted", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h00DF);
    chk("R8 ready high", {15'd0, ready}, 16'd1);
  endtask

  task automatic t_cfg_read;
    logic [15:0] v;
    wr(3'd2, 16'hABFF);
    rd(3'd2, v); chk("R9 cfg0 mask", v, 16'hABE0);
    wr(3'd3, 16'h5A1F);
    rd(3'd3, v); chk("R9 cfg1 full", v, 16'h5A1F);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    do_reset(1'b1);
    pulse(1'b0, 1'b1, 2'd2);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'hFFFF);
    for (int a = 5; a < 8; a++) wr(3'(a), 16'h0000);
    rd(3'd1, v); chk("R10 ctrl unchanged", v, 16'h1400);
    rd(3'd4, v); chk("R10 wp unchanged", v, 16'h0002);
    rd(3'd0, v); chk("R10 int unchanged", v, 16'h8080);
    rd(3'd2, v); chk("R10 cfg0 unchanged", v, 16'h40C0);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    do_reset(1'b1);
    pulse(1'b0, 1'b1, 2'd3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0000;
    evt_done = 1'b1; evt_op = 2'd1;
    @(negedge clk);
    bus_wr = 1'b0; evt_done = 1'b0;
    rd(3'd0, v); chk("R11 done survives mask", v, 16'h8020);
    rd(3'd1, v); chk("R11 errors kept", v, 16'h2400);
  endtask

  task automatic t_read_path;
    logic [15:0] v;
    rd(3'd6, v); chk("R12 unmapped zero", v, 16'h0000);
    @(negedge clk);
    bus_addr = 3'd4;
    @(negedge clk);
    chk("R12 hold without rd", bus_rdata, 16'h0000);
    rd(3'd4, v); chk("R12 one-cycle read", v, 16'h0002);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_cold = 1'b1; rst_warm = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_done = 1'b0; evt_err = 1'b0; evt_op = '0;
    t_cold_reset();
    t_warm_reset();
    t_and_mask();
    t_done_events();
    t_err_events();
    t_polarity();
    t_cfg_read();
    t_ignored();
    t_collision();
    t_read_path();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule